// File: doc/BRIEF.md
# USB Host Controller Mode Register with Functional-State Tracking

This block holds the operating-mode word of a USB host controller and the small state machine behind its functional-state field. Driver software reads and writes the word through a plain register port, addressed by byte offset inside the controller's register window. The word is decoded at offset 0x04 only. Hardware inputs supply a hardware reset, a software reset, a downstream resume-signaling detect and the resume-detected status flag.

The block drives the current functional state, a start-of-frame enable, a one-cycle pulse when frames begin, an interrupt-steering select, a remote wake-up request toward the host system and a reset request toward the root hub. Start-of-frame enable rises a fixed 1 ms after the state becomes operational. The 1 ms is counted in clock cycles derived from a clock-frequency parameter. The controller may change the state on its own in one case only: from suspend to resume, when it sees resume signaling from a downstream port.

Top module: `usb_hc_ctrl_reg`

## Requirements
- R1: A hardware reset (`hw_rst` high at a clock edge) sets the functional state to reset (code 00) and clears every field of the word. `func_state`, `sof_en`, `sof_start`, `smi_sel` and `remote_wake` are then 0, and a read at 0x04 returns 0.
- R2: `roothub_rst` is high in the cycle after each clock edge at which `hw_rst` is high, and low otherwise.
- R3: A software reset (`sw_rst` high, `hw_rst` low) sets the state to suspend (code 11). It clears the wake-up enable (bit 10) and the control bits 5:0, and it leaves the wake-up connected bit (bit 9) and the steering bit (bit 8) unchanged.
- R4: A write with `wr_en` high at offset 0x04 loads the word from `wdata` in the same edge. The read layout at 0x04 is: bit 10 wake-up enable, bit 9 wake-up connected, bit 8 steering, bits 7:6 state (00 reset, 01 resume, 10 operational, 11 suspend), bits 5:0 control bits, and bits 31:11 always zero. `rdata` is registered and shows the value in the cycle after the edge at which `rd_en` is sampled.
- R5: A write at any offset other than 0x04 changes nothing. A read at any other offset returns 0.
- R6: When the state is suspend and `resume_det` is high, the state becomes resume at the next edge. In the other states `resume_det` has no effect.
- R7: A driver write at 0x04 in the same cycle as a suspend-to-resume change wins: the state takes the written value.
- R8: `sof_en` rises exactly DELAY_CYC clock edges after the edge at which the state becomes operational, where DELAY_CYC = CLK_HZ/1000. `sof_start` is high for that one cycle only.
- R9: `sof_en` falls at the same edge at which the state leaves operational. A later entry into operational counts the full DELAY_CYC again.
- R10: `remote_wake` equals (wake-up enable AND `rd_status`) as sampled at the previous edge. The enable has no effect on `smi_sel`.
- R11: `smi_sel` equals the steering bit (bit 8): 0 selects the normal host bus interrupt and 1 selects the system-management interrupt.
- R12: Priority per edge is hardware reset, then software reset, then driver write, then the resume change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| hw_rst | input | 1 | Synchronous hardware reset, active high |
| sw_rst | input | 1 | Synchronous software reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset in the register window |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| resume_det | input | 1 | Resume signaling seen on a downstream port |
| rd_status | input | 1 | Resume-detected status flag |
| func_state | output | 2 | Current functional state |
| sof_en | output | 1 | Start-of-frame generation enable |
| sof_start | output | 1 | One-cycle pulse when frames begin |
| smi_sel | output | 1 | Interrupt steering select |
| remote_wake | output | 1 | Remote wake-up request to the host system |
| roothub_rst | output | 1 | Reset request to root hub and downstream ports |

## Verification
The hardest situations to reach are the collisions: a suspend-to-resume change that lands in the same cycle as a driver write, and a software reset that lands in the same cycle as a write. The bench first sets up suspend, then drives `resume_det` together with `wr_en` on one falling edge, so the competing sources meet at the same rising edge. The delay restart is reached by leaving operational partway through the count and re-entering it. The check that `sof_en` stays low for the whole window then proves that the counter was cleared.

// File: rtl/usb_hc_ctrl_pkg.sv
package usb_hc_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_RESET  = 2'b00,
    ST_RESUME = 2'b01,
    ST_OPER   = 2'b10,
    ST_SUSP   = 2'b11
  } hc_state_e;

  localparam int LOW_W    = 6;
  localparam int FS_LSB   = 6;
  localparam int IR_BIT   = 8;
  localparam int RWC_BIT  = 9;
  localparam int RWE_BIT  = 10;
  localparam int USED_W   = 11;
endpackage

// File: rtl/hc_state_track.sv
module hc_state_track
  import usb_hc_ctrl_pkg::*;
(
  input  logic      clk,
  input  logic      hw_rst,
  input  logic      sw_rst,
  input  logic      wr_hit,
  input  logic [1:0] wr_state,
  input  logic      resume_det,
  output hc_state_e state_q,
  output hc_state_e state_nxt,
  output logic      roothub_rst
);
  always_comb begin
    state_nxt = state_q;
    if (hw_rst)                                state_nxt = ST_RESET;
    else if (sw_rst)                           state_nxt = ST_SUSP;
    else if (wr_hit)                           state_nxt = hc_state_e'(wr_state);
    else if (state_q == ST_SUSP && resume_det) state_nxt = ST_RESUME;
  end

  always_ff @(posedge clk) begin
    state_q     <= state_nxt;
    roothub_rst <= hw_rst;
  end

  // R1
  hw_state_chk: assert property (@(posedge clk)
    hw_rst |=> (state_q == ST_RESET && roothub_rst));

  // R3
  sw_state_chk: assert property (@(posedge clk) disable iff (hw_rst)
    sw_rst |=> (state_q == ST_SUSP));

  // R6
  resume_move_chk: assert property (@(posedge clk) disable iff (hw_rst)
    (!sw_rst && !wr_hit && state_q == ST_SUSP && resume_det) |=> (state_q == ST_RESUME));

  // R6
  resume_ignore_chk: assert property (@(posedge clk) disable iff (hw_rst)
    (!sw_rst && !wr_hit && state_q != ST_SUSP) |=> $stable(state_q));

  // R7
  write_wins_chk: assert property (@(posedge clk) disable iff (hw_rst)
    (!sw_rst && wr_hit) |=> (state_q == $past(wr_state)));
endmodule

// File: rtl/hc_ctrl_fields.sv
module hc_ctrl_fields
  import usb_hc_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             hw_rst,
  input  logic             sw_rst,
  input  logic             wr_hit,
  input  logic [USED_W-1:0] wbits,
  output logic             rwe_q,
  output logic             rwc_q,
  output logic             ir_q,
  output logic [LOW_W-1:0] low_q
);
  always_ff @(posedge clk) begin
    if (hw_rst) begin
      rwe_q <= 1'b0;
      rwc_q <= 1'b0;
      ir_q  <= 1'b0;
      low_q <= '0;
    end else if (sw_rst) begin
      rwe_q <= 1'b0;
      low_q <= '0;
    end else if (wr_hit) begin
      rwe_q <= wbits[RWE_BIT];
      rwc_q <= wbits[RWC_BIT];
      ir_q  <= wbits[IR_BIT];
      low_q <= wbits[LOW_W-1:0];
    end
  end

  // R3
  sw_keep_chk: assert property (@(posedge clk) disable iff (hw_rst)
    sw_rst |=> (!rwe_q && low_q == '0 && $stable(rwc_q) && $stable(ir_q)));

  // R4
  wr_load_chk: assert property (@(posedge clk) disable iff (hw_rst)
    (wr_hit && !sw_rst) |=> (rwe_q == $past(wbits[RWE_BIT]) && ir_q == $past(wbits[IR_BIT])
                             && low_q == $past(wbits[LOW_W-1:0])));
endmodule

// File: rtl/hc_sof_delay.sv
module hc_sof_delay
  import usb_hc_ctrl_pkg::*;
#(
  parameter int DELAY_CYC = 50000
) (
  input  logic      clk,
  input  logic      hw_rst,
  input  hc_state_e state_q,
  input  hc_state_e state_nxt,
  output logic      sof_en,
  output logic      sof_start
);
  localparam int CNT_W = $clog2(DELAY_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    sof_start <= 1'b0;
    if (hw_rst || state_q != ST_OPER || state_nxt != ST_OPER) begin
      cnt_q  <= '0;
      sof_en <= 1'b0;
    end else if (!sof_en) begin
      if (cnt_q == LAST) begin
        sof_en    <= 1'b1;
        sof_start <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R9
  sof_off_chk: assert property (@(posedge clk) disable iff (hw_rst)
    (state_q != ST_OPER) |-> !sof_en);

  // R8
  sof_rise_chk: assert property (@(posedge clk) disable iff (hw_rst)
    $rose(sof_en) |-> (sof_start && state_q == ST_OPER && $past(state_q) == ST_OPER));

  // R8
  sof_pulse_chk: assert property (@(posedge clk) disable iff (hw_rst)
    sof_start |=> !sof_start);
endmodule

// File: rtl/usb_hc_ctrl_reg.sv
module usb_hc_ctrl_reg
  import usb_hc_ctrl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFFSET = 8'h04,
  parameter int CLK_HZ = 50_000_000
) (
  input  logic              clk,
  input  logic              hw_rst,
  input  logic              sw_rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              resume_det,
  input  logic              rd_status,
  output logic [1:0]        func_state,
  output logic              sof_en,
  output logic              sof_start,
  output logic              smi_sel,
  output logic              remote_wake,
  output logic              roothub_rst
);
  localparam int DELAY_CYC = CLK_HZ / 1000;

  logic             hit;
  logic             wr_hit;
  hc_state_e        state_q;
  hc_state_e        state_nxt;
  logic             rwe_q;
  logic             rwc_q;
  logic             ir_q;
  logic [LOW_W-1:0] low_q;
  logic [DATA_W-1:0] rd_word;
  logic             unused_hi;

  assign hit       = (addr == CTRL_OFFSET);
  assign wr_hit    = wr_en && hit;
  assign unused_hi = ^wdata[DATA_W-1:USED_W];

  hc_state_track u_state (
    .clk        (clk),
    .hw_rst     (hw_rst),
    .sw_rst     (sw_rst),
    .wr_hit     (wr_hit),
    .wr_state   (wdata[FS_LSB+1:FS_LSB]),
    .resume_det (resume_det),
    .state_q    (state_q),
    .state_nxt  (state_nxt),
    .roothub_rst(roothub_rst)
  );

  hc_ctrl_fields u_fields (
    .clk   (clk),
    .hw_rst(hw_rst),
    .sw_rst(sw_rst),
    .wr_hit(wr_hit),
    .wbits (wdata[USED_W-1:0]),
    .rwe_q (rwe_q),
    .rwc_q (rwc_q),
    .ir_q  (ir_q),
    .low_q (low_q)
  );

  hc_sof_delay #(.DELAY_CYC(DELAY_CYC)) u_sof (
    .clk      (clk),
    .hw_rst   (hw_rst),
    .state_q  (state_q),
    .state_nxt(state_nxt),
    .sof_en   (sof_en),
    .sof_start(sof_start)
  );

  always_comb begin
    rd_word                       = '0;
    rd_word[RWE_BIT]              = rwe_q;
    rd_word[RWC_BIT]              = rwc_q;
    rd_word[IR_BIT]               = ir_q;
    rd_word[FS_LSB+1:FS_LSB]      = state_q;
    rd_word[LOW_W-1:0]            = low_q;
  end

  always_ff @(posedge clk) begin
    if (hw_rst) begin
      rdata       <= '0;
      remote_wake <= 1'b0;
    end else begin
      rdata       <= (rd_en && hit) ? rd_word : '0;
      remote_wake <= rwe_q && rd_status;
    end
  end

  assign func_state = state_q;
  assign smi_sel    = ir_q;

  // R10
  wake_follow_chk: assert property (@(posedge clk) disable iff (hw_rst)
    remote_wake |-> $past(rwe_q && rd_status));

  // R5
  miss_ignore_chk: assert property (@(posedge clk) disable iff (hw_rst)
    (wr_en && !hit && !sw_rst && state_q != ST_SUSP) |=>
      ($stable(rwe_q) && $stable(rwc_q) && $stable(ir_q) && $stable(low_q) && $stable(state_q)));

  // R5
  miss_read_chk: assert property (@(posedge clk) disable iff (hw_rst)
    (rd_en && !hit) |=> (rdata == '0));
endmodule

// File: tb/tb_usb_hc_ctrl_reg.sv
module tb_usb_hc_ctrl_reg;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 10_000;
  localparam int DLY        = CLK_HZ / 1000;
  localparam int NVEC       = 7;

  // {addr, wdata, expected word read back at 0x04}
  localparam logic [71:0] VEC [NVEC] = '{
    {8'h04, 32'h0000_073F, 32'h0000_073F},
    {8'h08, 32'hFFFF_FFFF, 32'h0000_073F},
    {8'h04, 32'hFFFF_F8C0, 32'h0000_00C0},
    {8'h00, 32'h0000_0000, 32'h0000_00C0},
    {8'h04, 32'h0000_0155, 32'h0000_0155},
    {8'h04, 32'h0000_02AA, 32'h0000_02AA},
    {8'h04, 32'h0000_0400, 32'h0000_0400}
  };

  logic clk = 0;
  logic hw_rst = 1, sw_rst = 0, wr_en = 0, rd_en = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic resume_det = 0, rd_status = 0;
  logic [1:0] func_state;
  logic sof_en, sof_start, smi_sel, remote_wake, roothub_rst;
  int n_run = 0, n_fail = 0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_hc_ctrl_reg #(.CLK_HZ(CLK_HZ)) dut (
    .clk(clk), .hw_rst(hw_rst), .sw_rst(sw_rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .resume_det(resume_det),
    .rd_status(rd_status), .func_state(func_state), .sof_en(sof_en),
    .sof_start(sof_start), .smi_sel(smi_sel), .remote_wake(remote_wake),
    .roothub_rst(roothub_rst)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wdata = d;
    tick();
    wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_en = 1; addr = a;
    tick();
    rd_en = 0;
    d = rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); tick(); tick();
    // R1 / R2 reset state
    check("R1 state", {30'b0, func_state}, 32'h0);
    check("R1 outs", {28'b0, sof_en, sof_start, smi_sel, remote_wake}, 32'h0);
    check("R2 rh high", {31'b0, roothub_rst}, 32'h1);
    hw_rst = 0;
    tick();
    check("R2 rh low", {31'b0, roothub_rst}, 32'h0);
    rd(8'h04, rv); check("R1 read", rv, 32'h0);

    // R4 / R5 / R11 vector walk
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(8'h04, rv);
      check("R4 R5 word", rv, VEC[i][31:0]);
      check("R11 steer", {31'b0, smi_sel}, {31'b0, VEC[i][8]});
      check("R4 state", {30'b0, func_state}, {30'b0, VEC[i][7:6]});
    end
    rd(8'h10, rv); check("R5 miss read", rv, 32'h0);

    // R8 delay
    wr(8'h04, 32'h080);
    for (int k = 1; k < DLY; k++) tick();
    check("R8 before", {31'b0, sof_en}, 32'h0);
    tick();
    check("R8 rise", {30'b0, sof_en, sof_start}, 32'h3);
    tick();
    check("R8 pulse", {30'b0, sof_en, sof_start}, 32'h2);
    wr(8'h04, 32'h080);
    check("R8 rewrite keeps", {31'b0, sof_en}, 32'h1);

    // R9 leave and restart
    wr(8'h04, 32'h0C0);
    check("R9 drop", {29'b0, sof_en, func_state}, 32'h3);
    wr(8'h04, 32'h080);
    for (int k = 0; k < 4; k++) tick();
    wr(8'h04, 32'h0C0);
    wr(8'h04, 32'h080);
    for (int k = 1; k < DLY; k++) tick();
    check("R9 restart low", {31'b0, sof_en}, 32'h0);
    tick();
    check("R9 restart high", {31'b0, sof_en}, 32'h1);

    // R6 ignored in operational
    resume_det = 1; tick(); resume_det = 0;
    check("R6 oper ignore", {30'b0, func_state}, 32'h2);
    // R6 suspend to resume
    wr(8'h04, 32'h0C0);
    resume_det = 1; tick(); resume_det = 0;
    check("R6 move", {30'b0, func_state}, 32'h1);
    resume_det = 1; tick(); resume_det = 0;
    check("R6 resume ignore", {30'b0, func_state}, 32'h1);

    // R7 write beats resume
    wr(8'h04, 32'h0C0);
    resume_det = 1;
    wr(8'h04, 32'h080);
    resume_det = 0;
    check("R7 collide", {30'b0, func_state}, 32'h2);

    // R10 wake-up
    wr(8'h04, 32'h400);
    rd_status = 1; tick();
    check("R10 wake", {30'b0, remote_wake, smi_sel}, 32'h2);
    rd_status = 0; tick();
    check("R10 off", {31'b0, remote_wake}, 32'h0);
    wr(8'h04, 32'h000);
    rd_status = 1; tick(); rd_status = 0;
    check("R10 no en", {31'b0, remote_wake}, 32'h0);

    // R3 software reset
    wr(8'h04, 32'h7FF);
    sw_rst = 1; tick(); sw_rst = 0;
    rd(8'h04, rv); check("R3 sw", rv, 32'h3C0);

    // R12 sw beats write
    wr(8'h04, 32'h3BF);
    sw_rst = 1;
    wr(8'h04, 32'h000);
    sw_rst = 0;
    rd(8'h04, rv); check("R12 sw over wr", rv, 32'h3C0);

    // R12 hw beats everything
    hw_rst = 1; sw_rst = 1;
    wr(8'h04, 32'h7FF);
    hw_rst = 0; sw_rst = 0;
    rd(8'h04, rv); check("R12 hw over all", rv, 32'h0);
    check("R1 hw state", {30'b0, func_state}, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule